// File: doc/BRIEF.md
# Serial Frame Transmitter with Even Parity

This block turns an 8-bit parallel word into one framed character on a single serial line. A one-cycle load strobe captures the word while the transmitter is idle. The line then carries a low start bit, the eight data bits starting with the least significant, an even-parity bit and a high stop bit. A free-running bit-rate enable paces the frame: each pulse moves the line to the next frame bit, so a frame takes 11 pulses.

A ready flag is meant to drive an indicator LED. It drops on an accepted load and rises again only after the stop bit has been on the line for its full bit time. A load strobe that arrives while a frame is in progress is ignored. Both outputs come straight from flip-flops.

Top module: `frame_tx`

## Requirements
- R1: When `load_i` is 1 while `ready_o` is 1, `word_i` is captured, and on the next cycle `ready_o` is 0 and `line_o` is 0. The low line value is the start bit.
- R2: The start bit stays on `line_o` from the load until the first `bit_tick_i` pulse after it.
- R3: The bit-rate pulses numbered 1 to 8 after a load put data bits 0 to 7 of the captured word on `line_o`, in that order, least significant bit first.
- R4: The 9th pulse puts the parity bit on `line_o`. The parity bit is the XOR of the eight data bits, so the data bits and the parity bit together hold an even number of ones.
- R5: The 10th pulse puts the stop bit, value 1, on `line_o`.
- R6: The 11th pulse ends the stop bit. On the following cycle `ready_o` is 1 and `line_o` stays 1.
- R7: While a frame is in progress, `line_o` and `ready_o` change only on cycles in which `bit_tick_i` is 1.
- R8: A `load_i` pulse while `ready_o` is 0 is ignored. The frame in progress finishes with its original bits and with the original timing.
- R9: While the transmitter is idle, `line_o` is 1, and `bit_tick_i` pulses leave it unchanged.
- R10: A synchronous active-high `rst_i` sets `line_o` to 1 and `ready_o` to 1 on the next cycle, including when it arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Strobe that captures word_i |
| word_i | input | 8 | Parallel word to send |
| bit_tick_i | input | 1 | One-cycle bit-rate enable |
| line_o | output | 1 | Serial output, idles high |
| ready_o | output | 1 | High when no frame is in progress (LED drive) |

## Verification
The bench sends every one of the 256 words. It uses tick spacings of one, two and three cycles, so a design that advanced on the clock instead of the tick would show the wrong bit when the line is sampled just before each tick. The parity bit is compared against a count of ones, which catches odd parity or a parity taken from a partly shifted register. The bench also fires a load with the inverted word in the middle of some frames: a design that reloaded would emit the wrong remaining bits or restart the frame. Other cases covered are the ready flag rising one tick early or late around the stop bit, ticks on an idle line, and a reset in the middle of a frame.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_t;
endpackage

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  input  logic bit_tick_i,
  output logic accept_o,
  output logic shift_o,
  output logic send_data_o,
  output logic send_par_o,
  output logic send_one_o,
  output logic finish_o
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  tx_state_t       state_q, state_d;
  logic [CW-1:0]   idx_q, idx_d;
  logic            last_bit;

  assign last_bit = (idx_q == LAST);

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    accept_o    = 1'b0;
    shift_o     = 1'b0;
    send_data_o = 1'b0;
    send_par_o  = 1'b0;
    send_one_o  = 1'b0;
    finish_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_i) begin
          accept_o = 1'b1;
          state_d  = ST_START;
        end
      end
      ST_START: begin
        if (bit_tick_i) begin
          send_data_o = 1'b1;
          shift_o     = 1'b1;
          idx_d       = '0;
          state_d     = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bit_tick_i) begin
          if (last_bit) begin
            send_par_o = 1'b1;
            state_d    = ST_PAR;
          end else begin
            send_data_o = 1'b1;
            shift_o     = 1'b1;
            idx_d       = idx_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (bit_tick_i) begin
          send_one_o = 1'b1;
          state_d    = ST_STOP;
        end
      end
      ST_STOP: begin
        if (bit_tick_i) begin
          send_one_o = 1'b1;
          finish_o   = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              head_o,
  output logic              parity_o
);
  logic [DATA_W-1:0] sh_q;
  logic              par_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q  <= '0;
      par_q <= 1'b0;
    end else if (capture_i) begin
      sh_q  <= word_i;
      par_q <= ^word_i;
    end else if (shift_i) begin
      sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
    end
  end

  assign head_o   = sh_q[0];
  assign parity_o = par_q;
endmodule

// File: rtl/frame_tx_line.sv
module frame_tx_line (
  input  logic clk_i,
  input  logic rst_i,
  input  logic accept_i,
  input  logic send_data_i,
  input  logic send_par_i,
  input  logic send_one_i,
  input  logic finish_i,
  input  logic head_i,
  input  logic parity_i,
  output logic line_o,
  output logic ready_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      line_o  <= 1'b1;
      ready_o <= 1'b1;
    end else if (accept_i) begin
      line_o  <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      if (send_data_i) line_o <= head_i;
      if (send_par_i)  line_o <= parity_i;
      if (send_one_i)  line_o <= 1'b1;
      if (finish_i)    ready_o <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              bit_tick_i,
  output logic              line_o,
  output logic              ready_o
);
  logic accept, shift, send_data, send_par, send_one, finish;
  logic head, parity;

  frame_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .load_i      (load_i),
    .bit_tick_i  (bit_tick_i),
    .accept_o    (accept),
    .shift_o     (shift),
    .send_data_o (send_data),
    .send_par_o  (send_par),
    .send_one_o  (send_one),
    .finish_o    (finish)
  );

  frame_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .capture_i (accept),
    .shift_i   (shift),
    .word_i    (word_i),
    .head_o    (head),
    .parity_o  (parity)
  );

  frame_tx_line u_line (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .accept_i    (accept),
    .send_data_i (send_data),
    .send_par_i  (send_par),
    .send_one_i  (send_one),
    .finish_i    (finish),
    .head_i      (head),
    .parity_i    (parity),
    .line_o      (line_o),
    .ready_o     (ready_o)
  );
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              load_i,
  input logic [DATA_W-1:0] word_i,
  input logic              bit_tick_i,
  input logic              line_o,
  input logic              ready_o
);
  localparam int PW = $clog2(DATA_W + 4);
  localparam logic [PW-1:0] STOP_POS = PW'(DATA_W + 2);
  localparam logic [PW-1:0] PAR_POS  = PW'(DATA_W + 1);

  logic [PW-1:0] pos_q;
  logic          acc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pos_q <= '0;
      acc_q <= 1'b0;
    end else if (load_i && ready_o) begin
      pos_q <= '0;
      acc_q <= 1'b0;
    end else if (bit_tick_i && !ready_o) begin
      pos_q <= pos_q + 1'b1;
      if (pos_q >= 1 && pos_q <= PAR_POS) acc_q <= acc_q ^ line_o;
    end
  end

  AST_LOAD_DROPS_READY: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && ready_o) |=> (!ready_o && !line_o)); // R1
  AST_EVEN_PARITY: assert property (@(posedge clk_i) disable iff (rst_i)
    (bit_tick_i && !ready_o && pos_q == STOP_POS) |-> !acc_q); // R4
  AST_STOP_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    (bit_tick_i && !ready_o && pos_q == STOP_POS) |-> line_o); // R5
  AST_READY_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ready_o && !bit_tick_i) |=> ($stable(line_o) && !ready_o)); // R7
  AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && !ready_o && !bit_tick_i) |=> !ready_o); // R8
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_o |-> line_o); // R9
endmodule

bind frame_tx frame_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .load_i     (load_i),
  .word_i     (word_i),
  .bit_tick_i (bit_tick_i),
  .line_o     (line_o),
  .ready_o    (ready_o)
);

// File: tb/sim_frame_tx.sv
module sim_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       load;
  logic [7:0] word;
  logic       tick;
  logic       line;
  logic       ready;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_tx #(.DATA_W(8)) u0 (
    .clk_i(clk), .rst_i(rst), .load_i(load), .word_i(word),
    .bit_tick_i(tick), .line_o(line), .ready_o(ready)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic frame_bit(input logic [7:0] w, input int b);
    if (b < 8) return w[b];
    if (b == 8) begin
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += w[i];
      return logic'(ones % 2);
    end
    return 1'b1;
  endfunction

  task automatic send(input logic [7:0] w, input int gap, input bit intrude);
    logic prev;
    @(negedge clk); load = 1'b1; word = w;
    @(negedge clk); load = 1'b0; word = ~w;
    chk("R1 ready low", ready, 1'b0);
    chk("R1 line start", line, 1'b0);
    prev = 1'b0;
    for (int b = 0; b < 11; b++) begin
      for (int g = 1; g < gap; g++) @(negedge clk);
      if (intrude && b == 4) begin
        load = 1'b1;
        @(negedge clk); load = 1'b0;
        chk("R8 ignored load", ready, 1'b0);
      end
      if (b == 0) chk("R2 start held", line, 1'b0);
      else        chk("R7 held until tick", line, prev);
      chk("R7 ready held", ready, 1'b0);
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (b < 8)       chk("R3 data bit", line, frame_bit(w, b));
      else if (b == 8) chk("R4 parity", line, frame_bit(w, b));
      else if (b == 9) chk("R5 stop", line, 1'b1);
      else begin
        chk("R6 ready back", ready, 1'b1);
        chk("R6 line high", line, 1'b1);
      end
      if (b < 10) chk("R6 not early", ready, 1'b0);
      prev = frame_bit(w, b);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; load = 1'b0; word = '0; tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset line", line, 1'b1);
    chk("R10 reset ready", ready, 1'b1);
    rst = 1'b0;
    repeat (2) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
      chk("R9 idle line", line, 1'b1);
    end
    for (int w = 0; w < 256; w++) begin
      send(8'(w), 1 + (w % 3), (w % 5) == 2);
      if ((w % 16) == 0) begin
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R9 idle tick", line, 1'b1);
        chk("R9 idle ready", ready, 1'b1);
      end
    end
    @(negedge clk); load = 1'b1; word = 8'h5A;
    @(negedge clk); load = 1'b0;
    tick = 1'b1; @(negedge clk); @(negedge clk); tick = 1'b0;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R10 mid-frame line", line, 1'b1);
    chk("R10 mid-frame ready", ready, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule